// File: doc/BRIEF.md
# RNG Event Status and Interrupt Registers

This block sits beside a random bit generator and collects four kinds of event from it: a bias-balancer error, a continuous-output test error, an autocorrelation error and a collection-complete event. Each event arrives as a single-cycle pulse and is held in a sticky status bit. Every status bit has its own mask bit, and the unmasked status bits are combined into one interrupt line.

Software reaches the block through a plain register port with a write strobe, a word address and a combinational read path. The port gives access to the mask, status and clear registers, a statistics register that counts autocorrelation test starts and failures, and a soft-reset register. The autocorrelation error is raised only after a run of four failed tests in a row. Software cannot clear it. Only a block reset or a soft reset removes it.

Register word addresses: 0 mask (read/write), 1 status (read-only), 2 clear (write-only, reads 0), 3 statistics (read-only), 4 soft reset (write-only, reads 0).

Top module: `rng_evt_regs`

## Requirements
- R1: After reset the mask register reads 0xF, the status, statistics and clear registers read 0, and irq_o is low.
- R2: Status bit 3 is the balancer error, bit 2 is the continuous-test error, bit 1 is the autocorrelation error and bit 0 is collection complete. A pulse on a source sets its bit at the next clock edge, and the bit stays set after the pulse ends.
- R3: The mask register at address 0 uses the same bit positions as the status register and reads back what was written. irq_o is high exactly when some status bit is 1 and its mask bit is 0.
- R4: Writing the clear register at address 2 clears each of status bits 3, 2 and 0 whose write-data bit is 1, at the next edge. If a set pulse and a clear arrive for the same bit in the same cycle, the bit ends up set.
- R5: Status bit 1 ignores writes to the clear register, including write data 0xF.
- R6: Status bit 1 is set by the fourth autocorrelation failure pulse in a row. A pass pulse between failures restarts the run.
- R7: The statistics register at address 3 holds the count of test-start pulses in bits [13:0] and the count of failure pulses in bits [21:14]. Bits [31:22] read 0, and writes to this register are ignored.
- R8: Both statistics counts stop at their maximum values (16383 and 255) and do not wrap.
- R9: Writing 1 to bit 0 of the soft-reset register at address 4 clears all status bits, both counts and the failure run at the next edge. The clear wins over event pulses in the same cycle, and the mask register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bal_err_i | input | 1 | Balancer error pulse |
| ev_cont_err_i | input | 1 | Continuous-test error pulse |
| ev_collect_i | input | 1 | Collection-complete pulse |
| corr_start_i | input | 1 | Autocorrelation test started pulse |
| corr_fail_i | input | 1 | Autocorrelation test failed pulse |
| corr_pass_i | input | 1 | Autocorrelation test passed pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The properties assume the following about the inputs:
- A failure pulse and a pass pulse for the same test never arrive in the same cycle.
- The write strobe is low while reset is asserted.
- Event pulses last exactly one cycle unless the stimulus deliberately holds them to model back-to-back tests.

The stimulus drives every input on the falling edge and returns it to zero one cycle later. The one exception is the saturation burst, which holds the start and failure lines high for many cycles to model one test per cycle.

Collisions are produced on purpose and never left to chance. These are a set pulse against a clear write to the same bit, and an event pulse against a soft reset.

// File: rtl/rng_evt_pkg.sv
package rng_evt_pkg;
  localparam int NUM_SRC  = 4;
  localparam int ADDR_W   = 3;

  // status / mask bit positions
  localparam int BIT_DONE = 0;
  localparam int BIT_CORR = 1;
  localparam int BIT_CONT = 2;
  localparam int BIT_BAL  = 3;

  // bits software may clear through the clear register
  localparam logic [NUM_SRC-1:0] SW_CLEARABLE = 4'b1101;

  localparam logic [ADDR_W-1:0] A_MASK  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATS = 3'd3;
  localparam logic [ADDR_W-1:0] A_SRST  = 3'd4;
endpackage

// File: rtl/rng_sat_cnt.sv
module rng_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         at_max;

  assign at_max = &cnt_q;
  assign cnt_en = clr_i | (inc_i & ~at_max);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rng_evt_sticky.sv
module rng_evt_sticky #(
  parameter int               N         = 4,
  parameter logic [N-1:0]     CLR_OK    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] st_q;
  logic [N-1:0] st_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      if (flush_i)                      st_d[g] = 1'b0;
      else if (set_i[g])                st_d[g] = 1'b1;
      else if (CLR_OK[g] && sw_clr_i[g]) st_d[g] = 1'b0;
      else                              st_d[g] = st_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;
endmodule

// File: rtl/rng_corr_monitor.sv
module rng_corr_monitor #(
  parameter int TRY_W   = 14,
  parameter int FAIL_W  = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              start_i,
  input  logic              fail_i,
  input  logic              pass_i,
  output logic              err_o,
  output logic [TRY_W-1:0]  try_cnt_o,
  output logic [FAIL_W-1:0] fail_cnt_o
);
  localparam int RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;
  logic             run_en;
  logic             run_full;

  assign run_full = (run_q >= RUN_TOP);
  assign run_en   = flush_i | fail_i | pass_i;

  always_comb begin
    if (flush_i || !fail_i) run_d = '0;
    else if (run_full)      run_d = RUN_TOP;
    else                    run_d = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign err_o = fail_i & run_full & ~flush_i;

  rng_sat_cnt #(.W(TRY_W)) u_try (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (flush_i),
    .inc_i (start_i),
    .cnt_o (try_cnt_o)
  );

  rng_sat_cnt #(.W(FAIL_W)) u_fail (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (flush_i),
    .inc_i (fail_i),
    .cnt_o (fail_cnt_o)
  );
endmodule

// File: rtl/rng_evt_regs.sv
module rng_evt_regs
  import rng_evt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TRY_W   = 14,
  parameter int FAIL_W  = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_bal_err_i,
  input  logic              ev_cont_err_i,
  input  logic              ev_collect_i,
  input  logic              corr_start_i,
  input  logic              corr_fail_i,
  input  logic              corr_pass_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int STATS_W = TRY_W + FAIL_W;

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;
  logic               mask_we;
  logic               clr_we;
  logic               soft_clr;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] sw_clr_vec;
  logic [NUM_SRC-1:0] status_q;
  logic               corr_err;
  logic [TRY_W-1:0]   try_cnt;
  logic [FAIL_W-1:0]  fail_cnt;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = |reg_wdata_i[DATA_W-1:NUM_SRC];

  // write decode
  assign mask_we  = reg_wr_i && (reg_addr_i == A_MASK);
  assign clr_we   = reg_wr_i && (reg_addr_i == A_CLR);
  assign soft_clr = reg_wr_i && (reg_addr_i == A_SRST) && reg_wdata_i[0];

  // mask register
  assign mask_d = reg_wdata_i[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  // event capture
  always_comb begin
    set_vec           = '0;
    set_vec[BIT_BAL]  = ev_bal_err_i;
    set_vec[BIT_CONT] = ev_cont_err_i;
    set_vec[BIT_CORR] = corr_err;
    set_vec[BIT_DONE] = ev_collect_i;
  end

  assign sw_clr_vec = clr_we ? reg_wdata_i[NUM_SRC-1:0] : '0;

  rng_evt_sticky #(.N(NUM_SRC), .CLR_OK(SW_CLEARABLE)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (soft_clr),
    .set_i    (set_vec),
    .sw_clr_i (sw_clr_vec),
    .status_o (status_q)
  );

  rng_corr_monitor #(.TRY_W(TRY_W), .FAIL_W(FAIL_W), .RUN_LEN(RUN_LEN)) u_corr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (soft_clr),
    .start_i    (corr_start_i),
    .fail_i     (corr_fail_i),
    .pass_i     (corr_pass_i),
    .err_o      (corr_err),
    .try_cnt_o  (try_cnt),
    .fail_cnt_o (fail_cnt)
  );

  // interrupt
  assign irq_o = |(status_q & ~mask_q);

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MASK:  reg_rdata_o[NUM_SRC-1:0] = mask_q;
      A_STAT:  reg_rdata_o[NUM_SRC-1:0] = status_q;
      A_STATS: reg_rdata_o[STATS_W-1:0] = {fail_cnt, try_cnt};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rng_evt_regs_chk.sv
module rng_evt_regs_chk #(
  parameter int TRY_W  = 14,
  parameter int FAIL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_bal_err_i,
  input logic              ev_collect_i,
  input logic              corr_fail_i,
  input logic              clr_we,
  input logic              soft_clr,
  input logic [31:0]       reg_wdata_i,
  input logic [3:0]        status_q,
  input logic [3:0]        mask_q,
  input logic [TRY_W-1:0]  try_cnt,
  input logic [FAIL_W-1:0] fail_cnt,
  input logic              irq_o
);
  assert_bal_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bal_err_i && !soft_clr) |=> status_q[3]);

  assert_all_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'hF) |-> !irq_o);

  assert_clear_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && reg_wdata_i[0] && !ev_collect_i && !soft_clr) |=> !status_q[0]);

  assert_corr_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] && !soft_clr) |=> status_q[1]);

  assert_corr_needs_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!corr_fail_i && !status_q[1]) |=> !status_q[1]);

  assert_try_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&try_cnt) && !soft_clr) |=> (&try_cnt));

  assert_fail_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&fail_cnt) && !soft_clr) |=> (&fail_cnt));

  assert_soft_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (status_q == 4'h0 && try_cnt == '0 && fail_cnt == '0));

  assert_mask_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> $stable(mask_q));
endmodule

bind rng_evt_regs rng_evt_regs_chk #(.TRY_W(TRY_W), .FAIL_W(FAIL_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_bal_err_i (ev_bal_err_i),
  .ev_collect_i (ev_collect_i),
  .corr_fail_i  (corr_fail_i),
  .clr_we       (clr_we),
  .soft_clr     (soft_clr),
  .reg_wdata_i  (reg_wdata_i),
  .status_q     (status_q),
  .mask_q       (mask_q),
  .try_cnt      (try_cnt),
  .fail_cnt     (fail_cnt),
  .irq_o        (irq_o)
);

// File: tb/rng_evt_regs_tb.sv
module rng_evt_regs_tb_top;
  logic        clk;
  logic        rst_n;
  logic        ev_bal_err_i, ev_cont_err_i, ev_collect_i;
  logic        corr_start_i, corr_fail_i, corr_pass_i;
  logic        reg_wr_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [2:0]  a;
    logic [31:0] d;
    logic        irq;
    string       tag;
  } item_t;
  item_t exp_q[$];

  // event bundle order: {pass, fail, start, collect, cont, bal}
  localparam logic [5:0] E_BAL = 6'b000001, E_CONT = 6'b000010, E_DONE = 6'b000100,
                         E_START = 6'b001000, E_FAIL = 6'b010000, E_PASS = 6'b100000;

  rng_evt_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_bal_err_i(ev_bal_err_i), .ev_cont_err_i(ev_cont_err_i), .ev_collect_i(ev_collect_i),
    .corr_start_i(corr_start_i), .corr_fail_i(corr_fail_i), .corr_pass_i(corr_pass_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic set_ev(input logic [5:0] ev);
    {corr_pass_i, corr_fail_i, corr_start_i, ev_collect_i, ev_cont_err_i, ev_bal_err_i} = ev;
  endtask

  task automatic drive(input logic [5:0] ev, input bit wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    set_ev(ev);
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    set_ev(6'b0);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic pulse(input logic [5:0] ev);
    drive(ev, 1'b0, 3'd1, 32'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive(6'b0, 1'b1, a, d);
  endtask

  // driver: set the address and queue what the monitor must see
  task automatic expect_rd(input logic [2:0] a, input logic [31:0] d, input logic irq, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr_i = a;
    it.a = a; it.d = d; it.irq = irq; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compare shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (reg_rdata_o !== it.d || irq_o !== it.irq) begin
          errors++;
          $display("FAIL %s addr %0d: actual rdata=0x%08h irq=%b expected rdata=0x%08h irq=%b",
                   it.tag, it.a, reg_rdata_o, irq_o, it.d, it.irq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_ev(6'b0);
    reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(3'd0, 32'hF, 1'b0, "R1 mask reset");
    expect_rd(3'd1, 32'h0, 1'b0, "R1 status reset");
    expect_rd(3'd3, 32'h0, 1'b0, "R1 stats reset");
    expect_rd(3'd2, 32'h0, 1'b0, "R1 clear reads zero");

    // R2 sticky capture, masked so no interrupt
    pulse(E_BAL);
    expect_rd(3'd1, 32'h8, 1'b0, "R2 balancer bit3 sticky");

    // R3 mask and interrupt
    wr(3'd0, 32'h7);
    expect_rd(3'd0, 32'h7, 1'b1, "R3 mask readback irq on");
    pulse(E_CONT | E_DONE);
    expect_rd(3'd1, 32'hD, 1'b1, "R2 cont bit2 and done bit0");
    wr(3'd0, 32'hF);
    expect_rd(3'd1, 32'hD, 1'b0, "R3 all masked");
    wr(3'd0, 32'hE);
    expect_rd(3'd1, 32'hD, 1'b1, "R3 only bit0 unmasked");

    // R4 software clear and set-wins
    wr(3'd2, 32'h8);
    expect_rd(3'd1, 32'h5, 1'b1, "R4 clear bit3");
    drive(E_DONE, 1'b1, 3'd2, 32'h1);
    expect_rd(3'd1, 32'h5, 1'b1, "R4 set wins over clear");

    // R6 run of four failures, pass restarts
    for (int i = 0; i < 3; i++) pulse(E_START | E_FAIL);
    pulse(E_START | E_PASS);
    for (int i = 0; i < 3; i++) pulse(E_START | E_FAIL);
    expect_rd(3'd1, 32'h5, 1'b1, "R6 pass restarts run");
    pulse(E_START | E_FAIL);
    expect_rd(3'd1, 32'h7, 1'b1, "R6 fourth failure in a row");
    expect_rd(3'd3, (32'd7 << 14) | 32'd8, 1'b1, "R7 stats fields");

    // R5 autocorrelation bit ignores clear
    wr(3'd2, 32'hF);
    expect_rd(3'd1, 32'h2, 1'b0, "R5 bit1 survives clear");
    wr(3'd0, 32'hD);
    expect_rd(3'd1, 32'h2, 1'b1, "R3 bit1 unmasked");

    // R7 stats read-only
    wr(3'd3, 32'h0);
    expect_rd(3'd3, (32'd7 << 14) | 32'd8, 1'b1, "R7 stats write ignored");

    // R9 soft reset against a simultaneous event
    drive(E_BAL, 1'b1, 3'd4, 32'h1);
    expect_rd(3'd1, 32'h0, 1'b0, "R9 status flushed");
    expect_rd(3'd3, 32'h0, 1'b0, "R9 stats flushed");
    expect_rd(3'd0, 32'hD, 1'b0, "R9 mask kept");
    pulse(E_FAIL);
    expect_rd(3'd1, 32'h0, 1'b0, "R9 failure run flushed");
    expect_rd(3'd3, 32'd1 << 14, 1'b0, "R7 one failure counted");

    // R8 saturation burst
    for (int i = 0; i < 16390; i++) begin
      @(negedge clk);
      corr_start_i = 1'b1;
      corr_fail_i  = (i < 260);
    end
    @(negedge clk);
    set_ev(6'b0);
    expect_rd(3'd3, 32'h003F_FFFF, 1'b1, "R8 both counts saturated");
    expect_rd(3'd1, 32'h2, 1'b1, "R6 burst raised bit1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule